// File: doc/BRIEF.md
# Asynchronous PSRAM bus controller

This block sits between a synchronous host and a 16-bit pseudo-static RAM with an asynchronous interface. The host offers one request at a time on a valid/ready handshake: a word address, write data, a per-byte lane mask and a read/write flag. The controller turns each request into a timed sequence on the memory pins. It drives two chip selects of opposite polarity, an output enable, a write enable and one enable per byte lane, and it uses a split data bus with a separate output-enable for the tristate driver.

Every phase is timed by a down-counter. Its lengths are whole clock counts that the block derives at elaboration from nanosecond timing parameters and the clock period. Reads are chip-select controlled. The address settles one clock before the selects go active. Data is sampled on the last access clock and returned with a one-cycle valid pulse. A write is the overlap of the selects, the lane enables and a low write enable, and all of them end together at one clock edge. A request whose lane mask is zero is consumed without touching the memory.

Top module: `psram_async_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, `req_ready` is 1, the memory is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_lane_n`=2'b11, `mem_dq_oe`=0 and `rsp_valid`=0.
- R2: `mem_ce1_n` and `mem_ce2` always have opposite values. Selected means `mem_ce1_n`=0 and `mem_ce2`=1.
- R3: `mem_addr` takes the request address at the accept edge, which is one clock before the selects go active. It does not change while the memory is selected.
- R4: A read keeps the memory selected, with `mem_oe_n`=0 and `mem_we_n`=1, for exactly RA = ceil(max(tAA, tACE, tDBE, tDOE) / CLK_NS) clocks (7 at the defaults). `mem_lane_n[i]` is the inverse of `req_be[i]`. Bit 0 is the low byte (data bits 7:0) and bit 1 is the high byte (data bits 15:8).
- R5: Read data is sampled on the last access clock. `rsp_valid` is high for exactly one clock, RA+2 clocks after the accept edge. In `rsp_rdata`, a lane whose mask bit is 0 reads 0.
- R6: A write keeps the selects, the masked lane enables and `mem_we_n`=0 active for exactly WA = ceil(max(tSCE, tAW) / CLK_NS) clocks (6 at the defaults). All of them go inactive at the same clock edge.
- R7: `mem_dq_oe` is 1 exactly while `mem_we_n` is 0. During that time `mem_dq_o` equals the request write data.
- R8: After the accept edge, `req_ready` stays low for 1+RA+RR clocks on a read and for 1+WA+WR clocks on a write. Here RR = max(ceil(tRC/CLK_NS)-RA, 1) and WR = max(ceil(tWC/CLK_NS)-WA, 1), which gives 9 and 8 at the defaults.
- R9: A request with `req_be`=0 is accepted but starts no memory cycle. `req_ready` stays high, no `rsp_valid` follows, and the stored data is unchanged.
- R10: `mem_oe_n` and `mem_we_n` are never low together.
- R11: When `mem_oe_n` falls, `mem_we_n` was high and `mem_dq_oe` was 0 in the previous clock. So a write followed by a read has at least one clock with the bus released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte lane mask, bit 0 = low byte |
| rsp_valid | output | 1 | One-clock pulse: read data valid |
| rsp_rdata | output | 16 | Read data, unmasked lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Byte lane enables, active low, bit 0 = low byte |
| mem_dq_o | output | 16 | Data toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The assertions check several pin relations on every clock: the opposite polarity of the two selects, that OE and WE are never low together, that the bus is driven only under a low WE, that at least one lane is enabled while selected, that the address is stable before and during selection, that the bus is released before OE falls, and that the response is a single-clock pulse. The exact phase lengths, the response latency and the busy time can only be shown by the bench scenarios. The same holds for lane-masked merging of writes into a memory model, zeroing of unread lanes, and the absence of any cycle for an empty mask.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_RACC,
      PH_RREC,
      PH_WACT,
      PH_WREC
   } phase_e;

   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      if (ns <= 0) return 0;
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
   parameter int CW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   a_r4_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt != $past(cnt)));

endmodule

// File: rtl/psram_read_capture.sv
module psram_read_capture #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int DW    = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [LANES-1:0] lane_n,
   input  logic [DW-1:0]    dq_i,
   output logic             rsp_valid,
   output logic [DW-1:0]    rsp_rdata
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rsp_rdata[g*LANE_W +: LANE_W] <= '0;
         else if (cap)
            rsp_rdata[g*LANE_W +: LANE_W] <= lane_n[g] ? '0 : dq_i[g*LANE_W +: LANE_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_valid <= 1'b0;
      else        rsp_valid <= cap;
   end

   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/psram_ctrl_seq.sv
module psram_ctrl_seq
   import psram_ctrl_pkg::*;
#(
   parameter int AW     = 18,
   parameter int DW     = 16,
   parameter int LANES  = 2,
   parameter int CW     = 3,
   parameter int N_RACC = 7,
   parameter int N_RREC = 1,
   parameter int N_WACT = 6,
   parameter int N_WREC = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [AW-1:0]    req_addr,
   input  logic [DW-1:0]    req_wdata,
   input  logic [LANES-1:0] req_be,
   output logic             cap,
   output logic [AW-1:0]    mem_addr,
   output logic             mem_ce1_n,
   output logic             mem_ce2,
   output logic             mem_oe_n,
   output logic             mem_we_n,
   output logic [LANES-1:0] mem_lane_n,
   output logic [DW-1:0]    mem_dq_o,
   output logic             mem_dq_oe
);

   localparam logic [CW-1:0] L_RACC = CW'(N_RACC - 1);
   localparam logic [CW-1:0] L_RREC = CW'(N_RREC - 1);
   localparam logic [CW-1:0] L_WACT = CW'(N_WACT - 1);
   localparam logic [CW-1:0] L_WREC = CW'(N_WREC - 1);

   phase_e           phase;
   logic             op_wr;
   logic [LANES-1:0] op_be;
   logic             expired;
   logic             tmr_load;
   logic [CW-1:0]    tmr_val;

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = L_RACC;
      unique case (phase)
         PH_ADDR: begin
            tmr_load = 1'b1;
            tmr_val  = op_wr ? L_WACT : L_RACC;
         end
         PH_RACC: begin
            tmr_load = expired;
            tmr_val  = L_RREC;
         end
         PH_WACT: begin
            tmr_load = expired;
            tmr_val  = L_WREC;
         end
         default: ;
      endcase
   end

   psram_phase_timer #(.CW(CW)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (expired)
   );

   assign req_ready = (phase == PH_IDLE);
   assign cap       = (phase == PH_RACC) && expired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         op_wr      <= 1'b0;
         op_be      <= '0;
         mem_addr   <= '0;
         mem_dq_o   <= '0;
         mem_ce1_n  <= 1'b1;
         mem_ce2    <= 1'b0;
         mem_oe_n   <= 1'b1;
         mem_we_n   <= 1'b1;
         mem_lane_n <= '1;
         mem_dq_oe  <= 1'b0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (req_valid && req_be != '0) begin
                  mem_addr <= req_addr;
                  mem_dq_o <= req_wdata;
                  op_wr    <= req_write;
                  op_be    <= req_be;
                  phase    <= PH_ADDR;
               end
            end
            PH_ADDR: begin
               mem_ce1_n  <= 1'b0;
               mem_ce2    <= 1'b1;
               mem_lane_n <= ~op_be;
               if (op_wr) begin
                  mem_we_n  <= 1'b0;
                  mem_dq_oe <= 1'b1;
                  phase     <= PH_WACT;
               end else begin
                  mem_oe_n  <= 1'b0;
                  phase     <= PH_RACC;
               end
            end
            PH_RACC, PH_WACT: begin
               if (expired) begin
                  mem_ce1_n  <= 1'b1;
                  mem_ce2    <= 1'b0;
                  mem_oe_n   <= 1'b1;
                  mem_we_n   <= 1'b1;
                  mem_lane_n <= '1;
                  mem_dq_oe  <= 1'b0;
                  phase      <= (phase == PH_RACC) ? PH_RREC : PH_WREC;
               end
            end
            PH_RREC, PH_WREC: begin
               if (expired) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   a_r2_select_pair: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ce1_n != mem_ce2);
   a_r10_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));
   a_r7_drive_only_we: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !mem_we_n);
   a_r7_we_drives: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe);
   a_r3_addr_lead: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce1_n) |-> $stable(mem_addr));
   a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));
   a_r6_lane_active: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_ce1_n |-> (mem_lane_n != '1));
   a_r11_bus_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> ($past(mem_we_n) && !$past(mem_dq_oe)));
   a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce1_n && mem_oe_n && mem_we_n));

endmodule

// File: rtl/psram_async_ctrl.sv
module psram_async_ctrl
   import psram_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 16,
   parameter int LANE_W   = 8,
   parameter int CLK_NS   = 8,
   parameter int T_RC_NS  = 55,
   parameter int T_AA_NS  = 55,
   parameter int T_ACE_NS = 55,
   parameter int T_DOE_NS = 25,
   parameter int T_DBE_NS = 55,
   parameter int T_WC_NS  = 55,
   parameter int T_SCE_NS = 45,
   parameter int T_AW_NS  = 45,
   localparam int LANES   = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce1_n,
   output logic              mem_ce2,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [LANES-1:0]  mem_lane_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int RD_NS  = imax(imax(T_AA_NS, T_ACE_NS), imax(T_DOE_NS, T_DBE_NS));
   localparam int N_RACC = imax(ns_to_cyc(RD_NS, CLK_NS), 1);
   localparam int N_RREC = imax(ns_to_cyc(T_RC_NS, CLK_NS) - N_RACC, 1);
   localparam int N_WACT = imax(ns_to_cyc(imax(T_SCE_NS, T_AW_NS), CLK_NS), 1);
   localparam int N_WREC = imax(ns_to_cyc(T_WC_NS, CLK_NS) - N_WACT, 1);
   localparam int N_MAX  = imax(imax(N_RACC, N_RREC), imax(N_WACT, N_WREC));
   localparam int CW     = imax($clog2(N_MAX + 1), 1);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("clock period must be at least 1 ns");
   end
   if (LANE_W < 1 || DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("data width must be a whole number of lanes");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("address width must be positive");
   end

   logic cap;

   psram_ctrl_seq #(
      .AW     (ADDR_W),
      .DW     (DATA_W),
      .LANES  (LANES),
      .CW     (CW),
      .N_RACC (N_RACC),
      .N_RREC (N_RREC),
      .N_WACT (N_WACT),
      .N_WREC (N_WREC)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .req_be     (req_be),
      .cap        (cap),
      .mem_addr   (mem_addr),
      .mem_ce1_n  (mem_ce1_n),
      .mem_ce2    (mem_ce2),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_lane_n (mem_lane_n),
      .mem_dq_o   (mem_dq_o),
      .mem_dq_oe  (mem_dq_oe)
   );

   psram_read_capture #(
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) i_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap       (cap),
      .lane_n    (mem_lane_n),
      .dq_i      (mem_dq_i),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

endmodule

// File: tb/test_psram_async_ctrl.sv
module test_psram_async_ctrl;

   localparam int CLK = 8;

   function automatic int cyc(input int ns);
      if (ns <= 0) return 0;
      return (ns + CLK - 1) / CLK;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam int RA = mx(cyc(55), 1);
   localparam int RR = mx(cyc(55) - RA, 1);
   localparam int WA = mx(cyc(45), 1);
   localparam int WR = mx(cyc(55) - WA, 1);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_be = '0;
   logic        rsp_valid;
   logic [15:0] rsp_rdata;
   logic [17:0] mem_addr;
   logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [1:0]  mem_lane_n;
   logic [15:0] mem_dq_o;
   logic [15:0] mem_dq_i;

   always #(CLK/2) clk = ~clk;

   psram_async_ctrl i_psram_async_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n),
      .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // memory model: 64 words indexed by the low address bits
   logic [15:0] mdl [64];
   logic [15:0] shadow [64];
   wire  [5:0]  midx = mem_addr[5:0];
   wire         rd_on = !mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n;
   assign mem_dq_i = rd_on ? {mem_lane_n[1] ? 8'hEE : mdl[midx][15:8],
                              mem_lane_n[0] ? 8'hEE : mdl[midx][7:0]} : 16'h5A5A;

   // current operation, set by the host task
   logic        cur_wr;
   logic [17:0] cur_addr;
   logic [15:0] cur_d;
   logic [1:0]  cur_be;
   int          ce_starts = 0;
   int          sel_run = 0;
   int          we_run = 0;
   int          oe_run = 0;
   logic        p_ce1_n = 1'b1, p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
   logic [17:0] p_addr = '0;
   logic [15:0] w_data;
   logic [1:0]  w_lane_n;
   int          pin_bad = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_ce1_n == mem_ce2) pin_bad++;                   // R2
         if (!mem_oe_n && !mem_we_n) pin_bad++;                 // R10
         if (mem_dq_oe != !mem_we_n) pin_bad++;                 // R7
         if (!mem_ce1_n) sel_run++;
         if (!mem_we_n) begin
            we_run++;
            w_data = mem_dq_o;
            w_lane_n = mem_lane_n;
            if (we_run == 1) begin
               chk(mem_dq_o == cur_d, "R7 driven write data", mem_dq_o, cur_d);
               chk(mem_lane_n == ~cur_be, "R6 write lanes", mem_lane_n, ~cur_be);
            end
         end
         if (!mem_oe_n) oe_run++;
         if (!mem_ce1_n && p_ce1_n) begin
            ce_starts++;
            chk(mem_addr == p_addr && mem_addr == cur_addr, "R3 address leads select",
                mem_addr, cur_addr);
         end
         if (!mem_oe_n && p_oe_n) begin
            chk(p_we_n && !p_dq_oe, "R11 bus released before OE", {p_we_n, p_dq_oe}, 2'b10);
            chk(mem_we_n && mem_lane_n == ~cur_be, "R4 read pins",
                {mem_we_n, mem_lane_n}, {1'b1, ~cur_be});
         end
         if (!mem_ce1_n && !p_ce1_n && mem_addr != p_addr) pin_bad++; // R3
         if (mem_we_n && !p_we_n) begin
            chk(mem_ce1_n && mem_lane_n == 2'b11, "R6 single terminating edge",
                {mem_ce1_n, mem_lane_n}, 3'b111);
            if (!w_lane_n[0]) mdl[mem_addr[5:0]][7:0]  = w_data[7:0];
            if (!w_lane_n[1]) mdl[mem_addr[5:0]][15:8] = w_data[15:8];
         end
         if (mem_ce1_n && !p_ce1_n) begin
            if (cur_wr) begin
               chk(we_run == WA && sel_run == WA, "R6 write active length", we_run, WA);
            end else begin
               chk(oe_run == RA && sel_run == RA, "R4 read access length", oe_run, RA);
            end
            sel_run = 0; we_run = 0; oe_run = 0;
         end
         p_ce1_n = mem_ce1_n; p_we_n = mem_we_n; p_oe_n = mem_oe_n;
         p_dq_oe = mem_dq_oe; p_addr = mem_addr;
      end
   end

   task automatic issue(input logic wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] be, output int busy, output int lat,
                        output logic [15:0] rd, output int pulses);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      cur_wr = wr; cur_addr = a; cur_d = d; cur_be = be;
      req_write = wr; req_addr = a; req_wdata = d; req_be = be; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      busy = 0; lat = 0; rd = '0; pulses = 0;
      for (int n = 1; n < 40; n++) begin
         if (rsp_valid) begin
            pulses++;
            if (lat == 0) begin lat = n; rd = rsp_rdata; end
         end
         if (req_ready) break;
         busy++;
         @(negedge clk);
      end
      if (wr && be != 2'b00) begin
         if (be[0]) shadow[a[5:0]][7:0]  = d[7:0];
         if (be[1]) shadow[a[5:0]][15:8] = d[15:8];
      end
   endtask

   function automatic logic [15:0] expect_rd(input logic [5:0] i, input logic [1:0] be);
      return {be[1] ? shadow[i][15:8] : 8'h00, be[0] ? shadow[i][7:0] : 8'h00};
   endfunction

   function automatic logic [17:0] addr_of(input int i);
      return {12'(~(i * 37)), 6'(i)};
   endfunction

   initial begin
      int busy, lat, pulses, starts;
      logic [15:0] rd, ev;
      for (int k = 0; k < 64; k++) begin mdl[k] = '0; shadow[k] = '0; end
      cur_wr = 0; cur_addr = '0; cur_d = '0; cur_be = '0;
      repeat (3) @(negedge clk);
      chk(req_ready && mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n &&
          mem_lane_n == 2'b11 && !mem_dq_oe && !rsp_valid, "R1 reset state",
          {req_ready, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_lane_n, mem_dq_oe, rsp_valid},
          9'b110111100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 16; i++) begin
         issue(1'b1, addr_of(i), 16'h1111 * 16'(i) ^ 16'hC35A, 2'b11, busy, lat, rd, pulses);
         chk(busy == 1 + WA + WR, "R8 write busy time", busy, 1 + WA + WR);
         for (int be = 1; be < 4; be++) begin
            issue(1'b0, addr_of(i), 16'h0, 2'(be), busy, lat, rd, pulses);
            ev = expect_rd(6'(i), 2'(be));
            chk(rd == ev, "R5 read data lanes", rd, ev);
            chk(lat == RA + 2 && pulses == 1, "R5 response latency and pulse", lat, RA + 2);
            chk(busy == 1 + RA + RR, "R8 read busy time", busy, 1 + RA + RR);
         end
         issue(1'b1, addr_of(i), 16'hAB00 + 16'(i), 2'b01, busy, lat, rd, pulses);
         issue(1'b0, addr_of(i), 16'h0, 2'b11, busy, lat, rd, pulses);
         ev = expect_rd(6'(i), 2'b11);
         chk(rd == ev, "R6 low lane write merge", rd, ev);
         issue(1'b1, addr_of(i), 16'h00CD ^ 16'(i << 8), 2'b10, busy, lat, rd, pulses);
         issue(1'b0, addr_of(i), 16'h0, 2'b11, busy, lat, rd, pulses);
         ev = expect_rd(6'(i), 2'b11);
         chk(rd == ev, "R6 high lane write merge", rd, ev);
         chk(req_ready && mem_ce1_n && mem_oe_n && mem_we_n && !mem_dq_oe,
             "R1 idle pins between accesses", {req_ready, mem_ce1_n}, 2'b11);
      end

      starts = ce_starts;
      issue(1'b1, addr_of(3), 16'hFFFF, 2'b00, busy, lat, rd, pulses);
      chk(busy == 0, "R9 empty write keeps ready", busy, 0);
      issue(1'b0, addr_of(3), 16'h0, 2'b00, busy, lat, rd, pulses);
      chk(busy == 0 && pulses == 0, "R9 empty read no response", pulses, 0);
      repeat (4) @(negedge clk);
      chk(ce_starts == starts, "R9 no memory cycle", ce_starts, starts);
      issue(1'b0, addr_of(3), 16'h0, 2'b11, busy, lat, rd, pulses);
      ev = expect_rd(6'd3, 2'b11);
      chk(rd == ev, "R9 stored data unchanged", rd, ev);

      chk(pin_bad == 0, "R2 R3 R7 R10 per-cycle pin rules", pin_bad, 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog R8 actual=hung expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule